// File: doc/BRIEF.md
# SPI Host Transfer Engine

This block is the shifting core of a bus-attached SPI host. Software loads outgoing frames into a transmit FIFO and collects returned frames from a receive FIFO. It sets the frame length, the clock polarity and phase, and a frame budget through a small word-addressed register window. While the engine is enabled and in host mode, it pulls frames from the transmit FIFO one after another. It shifts each frame out MSB first on the data output and shifts the input line into a matching receive frame.

The serial clock rate comes from an external divider, which supplies a one-cycle `half_tick` strobe for every half period of the serial clock. Interrupt aggregation also sits outside the block and works from the status word. A 32-bit frame budget limits how many frames a burst may move. A sticky option holds the select lines asserted across gaps in the transmit FIFO until that budget is spent. The select lines can also be driven directly by software, and their active level can be inverted.

Top module: `spi_host_engine`

## Requirements
- R1: Register addresses: 0 control, 1 frame size, 2 status, 3 RX data, 4 TX data, 5 command, 6 select, 7 frame count. After reset the control register reads 0. The status word then shows TX empty (bit 10) and RX empty (bit 6) set, and all other status bits clear. The other status bits are: busy bit 14, TX full bit 8, RX full bit 4, underrun bit 3, overflow bit 2.
- R2: The frame size is a 6-bit field that resets to DATA_W. A write to it while control enable (bit 0) is 1 leaves it unchanged. A value of 0, or a value above DATA_W, shifts DATA_W bits.
- R3: Clock polarity (control bit 2) and clock phase (control bit 3) change only on a control write made while enable is 0. While no frame is in flight, the serial clock rests at the polarity value.
- R4: The clock output enable and the data output enable are low while enable is 0 and high while it is 1.
- R5: Each FIFO holds DEPTH frames. A TX data write to a full FIFO is dropped and flags nothing. The TX full and RX full status bits report a full FIFO.
- R6: Reading RX data while the RX FIFO is empty returns the last frame popped and pops nothing.
- R7: A frame starts only when enable, host mode (control bit 1) and a non-empty TX FIFO are all true. Each frame sends its low frame-size bits MSB first and pushes exactly one RX frame. With the data output looped back to the input, that RX frame equals the sent frame masked to the frame size, in all four clock modes.
- R8: Control bits 31:16 hold frame-count bits 15:0. A write to register 7 loads frame-count bits 31:16 from its write data bits 31:16 and ignores write data bits 15:0. Register 7 reads back the full 32-bit count.
- R9: With a non-zero frame count, no frame starts once that many frames have completed. A control write restarts the completed tally, and so does command bit 4. A count of 0 means no limit.
- R10: Command bit 3 empties the TX FIFO and command bit 2 empties the RX FIFO.
- R11: Select register bits 7:0 choose the lines, and select bit 8 gives software direct control of them. Outside direct mode, the lines are asserted while a frame is in flight. With sticky mode (control bit 4) on, they also stay asserted between frames until the count completes. In that state an empty TX FIFO sets underrun, which command bit 0 clears.
- R12: A frame that completes while the RX FIFO is full is discarded and sets overflow, which command bit 1 clears.
- R13: Select lines are active low. Select bit 9 makes them active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| half_tick | input | 1 | Serial clock half-period strobe |
| sclk_o | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data output enable |
| miso_i | input | 1 | Serial data in |
| sel_o | output | NSEL | Select lines |

## Verification
The bench keeps the default DATA_W of 8 and DEPTH of 32. A 32-entry FIFO can be filled, overfilled and overflowed in a few thousand cycles, so the full-FIFO drop and the RX overflow both come within reach. Every frame size from 0 to 8 is in range, so the bench can test the masking and the fallback for out-of-range sizes. The data output is looped back to the input, which turns every frame into a round trip the bench can predict. The `half_tick` strobe is driven randomly, so the clock edges fall at uneven spacings.

// File: rtl/spi_host_engine.sv
module spi_host_engine #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int NSEL   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              half_tick,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic [NSEL-1:0]   sel_o
);
  localparam int AW = $clog2(DEPTH);

  logic en, host, cpol, cpha, sticky, sel_dir, sel_inv, ovf, unr;
  logic [31:0] fc_tgt, done;
  logic [5:0] fsz;
  logic [NSEL-1:0] sel_bits;
  logic [DATA_W-1:0] tx_mem [DEPTH];
  logic [DATA_W-1:0] rx_mem [DEPTH];
  logic [AW:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [DATA_W-1:0] rx_last, sh_tx, sh_rx;
  logic busy, sclk_r, mo;
  logic [6:0] hc;

  wire wr_ctrl = reg_wr && reg_addr == 3'd0;
  wire wr_fsz  = reg_wr && reg_addr == 3'd1;
  wire wr_tx   = reg_wr && reg_addr == 3'd4;
  wire wr_cmd  = reg_wr && reg_addr == 3'd5;
  wire wr_sel  = reg_wr && reg_addr == 3'd6;
  wire wr_fc   = reg_wr && reg_addr == 3'd7;

  wire [AW:0] tx_cnt = tx_wp - tx_rp;
  wire [AW:0] rx_cnt = rx_wp - rx_rp;
  wire tx_empty = tx_cnt == 0;
  wire rx_empty = rx_cnt == 0;
  wire tx_full  = tx_cnt == (AW+1)'(DEPTH);
  wire rx_full  = rx_cnt == (AW+1)'(DEPTH);

  wire [5:0] nb = (fsz == 6'd0 || fsz > 6'(DATA_W)) ? 6'(DATA_W) : fsz;
  wire under_budget = fc_tgt == 32'd0 || done < fc_tgt;
  wire go   = en && host && !busy && !tx_empty && under_budget;
  wire fire = busy && half_tick;
  wire lead = !hc[0];
  wire fin  = fire && hc == {nb, 1'b0} - 7'd1;
  wire samp = fire && (lead ^ cpha);
  wire launch = fire && !(lead ^ cpha) && !fin;
  wire [DATA_W-1:0] rx_in = {sh_rx[DATA_W-2:0], miso_i};
  wire [DATA_W-1:0] rx_word = cpha ? rx_in : sh_rx;
  wire [DATA_W-1:0] tx_word = tx_mem[tx_rp[AW-1:0]] << (DATA_W - int'(nb));
  wire rx_pop = reg_rd && reg_addr == 3'd3 && !rx_empty;
  wire clr_cnt = wr_ctrl || (wr_cmd && reg_wdata[4]);

  wire hold = en && (busy || (sticky && fc_tgt != 0 && done != 0 && done < fc_tgt));
  wire [NSEL-1:0] asserted = sel_dir ? sel_bits : (hold ? sel_bits : '0);
  assign sel_o   = sel_inv ? asserted : ~asserted;
  assign sclk_o  = sclk_r;
  assign mosi_o  = mo;
  assign sclk_oe = en;
  assign mosi_oe = en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, host, cpol, cpha, sticky} <= '0;
      fc_tgt <= '0;
      fsz <= 6'(DATA_W);
      {sel_dir, sel_inv} <= '0;
      sel_bits <= '0;
    end else begin
      if (wr_ctrl) begin
        {sticky, host, en} <= {reg_wdata[4], reg_wdata[1:0]};
        if (!en) {cpha, cpol} <= reg_wdata[3:2];
        fc_tgt[15:0] <= reg_wdata[31:16];
      end
      if (wr_fc) fc_tgt[31:16] <= reg_wdata[31:16];
      if (wr_fsz && !en) fsz <= reg_wdata[5:0];
      if (wr_sel) begin
        sel_bits <= reg_wdata[NSEL-1:0];
        {sel_inv, sel_dir} <= reg_wdata[9:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_tx && !tx_full) tx_mem[tx_wp[AW-1:0]] <= reg_wdata[DATA_W-1:0];
    if (fin && !rx_full) rx_mem[rx_wp[AW-1:0]] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {tx_wp, tx_rp, rx_wp, rx_rp} <= '0;
      rx_last <= '0;
      {ovf, unr} <= '0;
      done <= '0;
    end else begin
      if (wr_cmd && reg_wdata[3]) {tx_wp, tx_rp} <= '0;
      else begin
        if (wr_tx && !tx_full) tx_wp <= tx_wp + 1'b1;
        if (go) tx_rp <= tx_rp + 1'b1;
      end
      if (wr_cmd && reg_wdata[2]) {rx_wp, rx_rp} <= '0;
      else begin
        if (fin && !rx_full) rx_wp <= rx_wp + 1'b1;
        if (rx_pop) begin
          rx_rp <= rx_rp + 1'b1;
          rx_last <= rx_mem[rx_rp[AW-1:0]];
        end
      end
      if (clr_cnt) done <= '0;
      else if (fin) done <= done + 32'd1;
      if (fin && rx_full) ovf <= 1'b1;
      else if (wr_cmd && reg_wdata[1]) ovf <= 1'b0;
      if (hold && !busy && tx_empty) unr <= 1'b1;
      else if (wr_cmd && reg_wdata[0]) unr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; hc <= '0; sclk_r <= 1'b0; mo <= 1'b0;
      sh_tx <= '0; sh_rx <= '0;
    end else if (!en) begin
      busy <= 1'b0;
      sclk_r <= cpol;
    end else if (go) begin
      busy <= 1'b1;
      hc <= '0;
      sh_rx <= '0;
      sh_tx <= cpha ? tx_word : tx_word << 1;
      if (!cpha) mo <= tx_word[DATA_W-1];
    end else if (fire) begin
      sclk_r <= ~sclk_r;
      hc <= hc + 7'd1;
      if (samp) sh_rx <= rx_in;
      if (launch) begin
        mo <= sh_tx[DATA_W-1];
        sh_tx <= sh_tx << 1;
      end
      if (fin) busy <= 1'b0;
    end else if (!busy) begin
      sclk_r <= cpol;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata = {fc_tgt[15:0], 11'd0, sticky, cpha, cpol, host, en};
      3'd1: reg_rdata = {26'd0, fsz};
      3'd2: begin
        reg_rdata[14] = busy;
        reg_rdata[10] = tx_empty;
        reg_rdata[8]  = tx_full;
        reg_rdata[6]  = rx_empty;
        reg_rdata[4]  = rx_full;
        reg_rdata[3]  = unr;
        reg_rdata[2]  = ovf;
      end
      3'd3: reg_rdata[DATA_W-1:0] = rx_empty ? rx_last : rx_mem[rx_rp[AW-1:0]];
      3'd6: begin
        reg_rdata[NSEL-1:0] = sel_bits;
        reg_rdata[9:8] = {sel_inv, sel_dir};
      end
      3'd7: reg_rdata = fc_tgt;
      default: reg_rdata = '0;
    endcase
  end

  assert_fsz_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(fsz));
  assert_mode_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable({cpol, cpha}));
  assert_idle_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol)) |-> sclk_r == cpol);
  assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= (AW+1)'(DEPTH) && rx_cnt <= (AW+1)'(DEPTH));
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(fc_tgt) == 0 || $past(done) < $past(fc_tgt)));
endmodule

// File: tb/spi_host_engine_test.sv
module spi_host_engine_test;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, half_tick = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic sclk_o, sclk_oe, mosi_o, mosi_oe, miso_i;
  logic [7:0] sel_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  assign miso_i = mosi_o;

  spi_host_engine uut (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .reg_rdata, .half_tick, .sclk_o, .sclk_oe, .mosi_o, .mosi_oe, .miso_i, .sel_o);

  initial forever begin
    @(negedge clk);
    half_tick = 1'($urandom_range(0, 1));
  end

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  function automatic logic [31:0] ctrl(bit e, bit h, bit pol, bit pha, bit stk, logic [15:0] fc);
    return {fc, 11'd0, stk, pha, pol, h, e};
  endfunction

  function automatic logic [31:0] masked(logic [31:0] d, int n);
    int eff = (n == 0 || n > 8) ? 8 : n;
    return d & ((32'd1 << eff) - 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, bit pop, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = pop;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd2, 0, s);
      if (!s[14] && s[10]) break;
    end
    idle(4);
  endtask

  logic [31:0] v, s, q[$];

  initial begin
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1;
    idle(2);

    rd(3'd2, 0, s);
    chk("R1 reset status", s, 32'h0000_0440);
    rd(3'd0, 0, v);
    chk("R1 reset control", v, 0);
    chk("R13 reset select lines idle high", sel_o, 8'hFF);
    chk("R4 outputs released while disabled", {sclk_oe, mosi_oe}, 2'b00);

    wr(3'd7, 32'hABCD_1234);
    rd(3'd7, 0, v);
    chk("R8 upper count write ignores low half", v, 32'hABCD_0000);
    wr(3'd7, 0);

    wr(3'd1, 5);
    wr(3'd0, ctrl(1, 1, 0, 0, 0, 0));
    chk("R4 outputs driven while enabled", {sclk_oe, mosi_oe}, 2'b11);
    wr(3'd1, 3);
    rd(3'd1, 0, v);
    chk("R2 frame size locked while enabled", v, 5);
    wr(3'd0, ctrl(1, 1, 1, 1, 0, 0));
    rd(3'd0, 0, v);
    chk("R3 mode bits locked while enabled", v[3:2], 2'b00);
    wr(3'd0, 0);
    wr(3'd0, ctrl(0, 1, 1, 0, 0, 0));
    idle(2);
    chk("R3 idle clock follows polarity", sclk_o, 1);

    wr(3'd0, ctrl(1, 0, 0, 0, 0, 0));
    wr(3'd4, 8'h5A);
    idle(200);
    rd(3'd2, 0, s);
    chk("R7 no start without host mode", {s[14], s[10], s[6]}, 3'b001);
    wr(3'd0, 0);
    wr(3'd5, 32'h0C);

    for (int it = 0; it < 14; it++) begin
      int fs = (it == 0) ? 0 : (it == 1) ? 12 : $urandom_range(1, 8);
      bit pol = 1'($urandom_range(0, 1));
      bit pha = 1'($urandom_range(0, 1));
      int k = $urandom_range(1, 6);
      q.delete();
      wr(3'd0, 0);
      wr(3'd1, fs);
      wr(3'd0, ctrl(0, 1, pol, pha, 0, 0));
      for (int j = 0; j < k; j++) begin
        logic [31:0] d = $urandom;
        q.push_back(d);
        wr(3'd4, d);
      end
      wr(3'd0, ctrl(1, 1, pol, pha, 0, 0));
      wait_done();
      chk("R3 clock rests at polarity after frames", sclk_o, pol);
      for (int j = 0; j < k; j++) begin
        rd(3'd3, 1, v);
        chk($sformatf("R7 loopback frame mode %0d%0d size %0d", pol, pha, fs), v, masked(q[j], fs));
      end
      rd(3'd2, 0, s);
      chk("R7 one RX frame per TX frame", s[6], 1);
    end

    wr(3'd0, 0);
    wr(3'd1, 8);
    wr(3'd5, 32'h0C);
    for (int j = 0; j < 33; j++) wr(3'd4, j + 8'h40);
    rd(3'd2, 0, s);
    chk("R5 TX full flag", s[8], 1);
    wr(3'd0, ctrl(1, 1, 0, 0, 0, 0));
    wait_done();
    rd(3'd2, 0, s);
    chk("R5 RX full flag, no overflow", {s[4], s[2]}, 2'b10);
    for (int j = 0; j < 32; j++) begin
      rd(3'd3, 1, v);
      chk("R5 frame kept in order", v, j + 8'h40);
    end
    rd(3'd2, 0, s);
    chk("R5 dropped write sent nothing", s[6], 1);
    rd(3'd3, 1, v);
    chk("R6 empty read returns last", v, 8'h5F);
    rd(3'd3, 1, v);
    chk("R6 empty read repeats", v, 8'h5F);

    for (int j = 0; j < 33; j++) begin
      wr(3'd4, j + 8'h80);
      if (j == 31) wait_done();
    end
    wait_done();
    rd(3'd2, 0, s);
    chk("R12 overflow flag set", s[2], 1);
    rd(3'd3, 0, v);
    chk("R12 oldest frame kept", v, 8'h80);
    wr(3'd5, 32'h02);
    rd(3'd2, 0, s);
    chk("R12 overflow cleared by command", s[2], 0);
    wr(3'd5, 32'h04);
    rd(3'd2, 0, s);
    chk("R10 RX reset empties FIFO", s[6], 1);

    wr(3'd0, 0);
    for (int j = 0; j < 3; j++) wr(3'd4, j);
    wr(3'd5, 32'h08);
    rd(3'd2, 0, s);
    chk("R10 TX reset empties FIFO", s[10], 1);

    for (int j = 0; j < 5; j++) wr(3'd4, j + 8'h10);
    wr(3'd0, ctrl(1, 1, 0, 0, 0, 3));
    idle(1500);
    rd(3'd2, 0, s);
    chk("R9 budget stops further frames", {s[14], s[10]}, 2'b00);
    begin
      int n = 0;
      for (int j = 0; j < 8; j++) begin
        rd(3'd2, 0, s);
        if (!s[6]) begin rd(3'd3, 1, v); n++; end
      end
      chk("R9 frames moved under budget", n, 3);
      wr(3'd5, 32'h10);
      wait_done();
      n = 0;
      for (int j = 0; j < 8; j++) begin
        rd(3'd2, 0, s);
        if (!s[6]) begin rd(3'd3, 1, v); n++; end
      end
      chk("R9 count clear releases rest", n, 2);
    end

    wr(3'd0, 0);
    wr(3'd5, 32'h0F);
    wr(3'd6, 32'h01);
    wr(3'd0, ctrl(1, 1, 0, 0, 1, 2));
    wr(3'd4, 8'hC3);
    idle(400);
    chk("R11 sticky select held in gap", sel_o, 8'hFE);
    rd(3'd2, 0, s);
    chk("R11 underrun while held", {s[14], s[3]}, 2'b01);
    wr(3'd4, 8'h3C);
    idle(400);
    chk("R11 select released at budget", sel_o, 8'hFF);
    wr(3'd5, 32'h01);
    rd(3'd2, 0, s);
    chk("R11 underrun cleared", s[3], 0);

    wr(3'd6, 32'h105);
    chk("R13 direct select active low", sel_o, 8'hFA);
    wr(3'd6, 32'h305);
    chk("R13 direct select inverted", sel_o, 8'h05);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule